// File: doc/BRIEF.md
# Inter-Hart Software Interrupt Register Block

This block gives every hart in a cluster a way to raise a software interrupt on any other hart by storing to a memory-mapped word. Each hart owns one 32-bit register, packed at a 4-byte stride from offset zero inside a 16 KiB window. Bit 0 of the stored value is the only bit that has meaning; a store with bit 0 set raises the interrupt of the hart that owns the register.

A build-time parameter picks one of two flavours. In the machine flavour each register holds a pending bit that drives a level output. The bit can be set and cleared by stores, and software can read it back. In the supervisor flavour the block can only post: a store with bit 0 set emits a single-cycle set pulse toward a pending flop that the receiving hart keeps in its own control state. Stores with bit 0 clear do nothing, and every read returns zero. Both flavours use a plain 32-bit register port: one request per cycle, with the read data returned one cycle after the request.

Top module: `ipi_swi_regs`

## Requirements
- R1: After synchronous reset every interrupt output is 0, and a read of any hart register returns 0.
- R2: A write with bit 0 = 1 to the register at byte offset 4*k (k < NUM_HARTS) raises output k from the cycle after the write. In machine flavour the output then holds high.
- R3: In machine flavour, a write with bit 0 = 0 to hart k's register drops output k from the cycle after the write.
- R4: A read request produces reg_rvalid = 1 on the following cycle. In machine flavour reg_rdata then carries hart k's pending state in bit 0, and bits 31..1 are 0.
- R5: In supervisor flavour, a write with bit 0 = 1 yields exactly one cycle of output k high, on the cycle after the write.
- R6: In supervisor flavour, a write with bit 0 = 0 produces no output activity, and every read returns 0.
- R7: Bits 31..1 of write data are ignored. 0xFFFF_FFFE acts as a clear, and 0x0000_0003 acts as a set.
- R8: An access whose address bits [1:0] are not 00 is ignored on write and reads as 0.
- R9: An access to a word index at or above NUM_HARTS (up to the end of the 0x4000 window) is ignored on write and reads as 0.
- R10: A write changes only the output of the addressed hart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Request valid for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 14 | Byte offset within the window |
| reg_wdata | input | 32 | Write data; only bit 0 is used |
| reg_rvalid | output | 1 | Read data valid (one cycle after a read request) |
| reg_rdata | output | 32 | Read data |
| swi_out | output | NUM_HARTS | Per-hart software interrupt: a level in machine flavour, a set pulse in supervisor flavour |

## Verification
A corrupted pending bit shows on that hart's output from the next cycle. In machine flavour it also shows in the read data of the next read of that register, so a stale or misrouted bit is caught within one cycle of the store. A decode fault, such as a misaligned or out-of-range hit or a wrong word index, appears as a neighbour's output changing on the cycle after the store. A supervisor-flavour pulse that lasts two cycles, or a pulse caused by a zero store, is visible on the second cycle. The machine and supervisor instances see identical traffic, so every difference between the flavours is compared on the same cycle.

// File: rtl/ipi_swi_pkg.sv
// Package: shared constants and helpers for the inter-hart software
// interrupt block. Assumes a 32-bit register port and a byte-addressed window.
package ipi_swi_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned WORD_BYTES  = WORD_W / 8;
    localparam int unsigned OFS_W       = $clog2(WORD_BYTES);
    localparam int unsigned MAX_HARTS   = 4095;

    // Decoded request as seen by the per-hart cells and the read path.
    typedef struct packed {
        logic wr_bit;   // bit 0 of the store data
        logic rd_req;   // accepted read request
        logic rd_hit;   // read targets an implemented register
    } ipi_req_t;

    // True when the low byte-offset bits select a whole word.
    function automatic logic word_aligned(input logic [OFS_W-1:0] ofs);
        return (ofs == '0);
    endfunction

endpackage

// File: rtl/ipi_swi_decode.sv
// Address decoder: splits the byte offset into a word index and produces
// one-hot write strobes plus a read hit flag. Assumes at most one request per
// cycle and that ADDR_W covers exactly the register window.
module ipi_swi_decode
    import ipi_swi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 14,
    localparam int unsigned IDX_W    = ADDR_W - OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [NUM_HARTS-1:0] wr_stb,
    output ipi_req_t             req,
    output logic [IDX_W-1:0]     rd_idx
);

    logic [IDX_W-1:0] word_idx;
    logic             in_range;
    logic             aligned;
    logic             hit;

    // Word index and legality of the current address.
    always_comb begin
        word_idx = reg_addr[ADDR_W-1:OFS_W];
        aligned  = word_aligned(reg_addr[OFS_W-1:0]);
        in_range = ({1'b0, word_idx} < (IDX_W+1)'(NUM_HARTS));
        hit      = aligned && in_range;
    end

    // Request summary handed to the cells and the read path.
    always_comb begin
        req.wr_bit = reg_wdata[0];
        req.rd_req = reg_sel && !reg_wr;
        req.rd_hit = reg_sel && !reg_wr && hit;
        rd_idx     = word_idx;
    end

    // One strobe per implemented hart register.
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_stb
        assign wr_stb[h] = reg_sel && reg_wr && hit && (word_idx == IDX_W'(h));
    end

    // R10: a store never reaches more than one hart register.
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));
    // R8: a misaligned store never strobes a register.
    a_r8_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_addr[OFS_W-1:0] != '0) |-> (wr_stb == '0));

endmodule

// File: rtl/ipi_swi_cell.sv
// Per-hart interrupt cell. In machine flavour it holds a pending flop that
// stores set and clear; in supervisor flavour it emits a one-cycle set pulse
// and ignores clears. Assumes the strobe is already qualified by the decoder.
module ipi_swi_cell #(
    parameter bit SUPERVISOR_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic irq
);

    logic irq_q;

    if (SUPERVISOR_MODE) begin : g_sup
        // Pulse for exactly the cycle after a setting store.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= wr_stb && wr_bit;
        end

        // R5: a pulse never lasts two cycles without a fresh setting store.
        a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_q && !(wr_stb && wr_bit)) |=> !irq_q);
        // R6: a clearing store causes no pulse.
        a_r6_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && !wr_bit) |=> !irq_q);
    end else begin : g_mach
        // Pending bit follows bit 0 of each store to this register.
        always_ff @(posedge clk) begin
            if (!rst_n)      irq_q <= 1'b0;
            else if (wr_stb) irq_q <= wr_bit;
        end

        // R3: a clearing store drops the level.
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && !wr_bit) |=> !irq_q);
        // R10: without a store to this hart the level is unchanged.
        a_r10_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_stb |=> $stable(irq_q));
    end

    // R2: a setting store raises the output on the next cycle.
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_bit) |=> irq_q);

    assign irq = irq_q;

endmodule

// File: rtl/ipi_swi_readback.sv
// Read path: returns the addressed pending bit one cycle after a read
// request. Supervisor flavour returns zero. Assumes rd_idx is meaningful
// only when rd_hit is set.
module ipi_swi_readback
    import ipi_swi_pkg::*;
#(
    parameter int unsigned NUM_HARTS       = 4,
    parameter int unsigned IDX_W           = 12,
    parameter bit          SUPERVISOR_MODE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ipi_req_t             req,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [NUM_HARTS-1:0] pend,
    output logic                 rvalid,
    output logic [WORD_W-1:0]    rdata
);

    logic              sel_bit;
    logic              rvalid_q;
    logic [WORD_W-1:0] rdata_q;

    // Pick the addressed pending bit; zero for misses and supervisor flavour.
    if (SUPERVISOR_MODE) begin : g_sup
        assign sel_bit = 1'b0;
    end else begin : g_mach
        always_comb begin
            sel_bit = 1'b0;
            for (int h = 0; h < NUM_HARTS; h++) begin
                if (req.rd_hit && rd_idx == IDX_W'(h)) sel_bit = pend[h];
            end
        end
    end

    // Register the response for one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= req.rd_req;
            rdata_q  <= {{(WORD_W-1){1'b0}}, sel_bit};
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;

    // R4: every read request is answered on the next cycle.
    a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req.rd_req |=> rvalid);
    // R9: a read that misses returns zero.
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req.rd_req && !req.rd_hit) |=> (rdata == '0));

endmodule

// File: rtl/ipi_swi_regs.sv
// Top: inter-hart software interrupt registers, one word per hart at a
// 4-byte stride. SUPERVISOR_MODE selects set/clear level outputs with read
// back (0) or set-only pulses with zero read back (1). Assumes
// NUM_HARTS <= 4095 and a window of WINDOW_BYTES, a power of two.
module ipi_swi_regs
    import ipi_swi_pkg::*;
#(
    parameter int unsigned NUM_HARTS       = 4,
    parameter int unsigned WINDOW_BYTES    = 16384,
    parameter bit          SUPERVISOR_MODE = 1'b0,
    localparam int unsigned ADDR_W         = $clog2(WINDOW_BYTES),
    localparam int unsigned IDX_W          = ADDR_W - OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic                 reg_rvalid,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_HARTS-1:0] swi_out
);

    logic [NUM_HARTS-1:0] wr_stb;
    logic [IDX_W-1:0]     rd_idx;
    ipi_req_t             req;

    ipi_swi_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .wr_stb    (wr_stb),
        .req       (req),
        .rd_idx    (rd_idx)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        ipi_swi_cell #(
            .SUPERVISOR_MODE (SUPERVISOR_MODE)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (wr_stb[h]),
            .wr_bit (req.wr_bit),
            .irq    (swi_out[h])
        );
    end

    ipi_swi_readback #(
        .NUM_HARTS       (NUM_HARTS),
        .IDX_W           (IDX_W),
        .SUPERVISOR_MODE (SUPERVISOR_MODE)
    ) u_readback (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .rd_idx (rd_idx),
        .pend   (swi_out),
        .rvalid (reg_rvalid),
        .rdata  (reg_rdata)
    );

    // R4: upper read bits are always zero on a response.
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> (reg_rdata[WORD_W-1:1] == '0));
    // R6: supervisor flavour responses are zero.
    a_r6_sup_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (SUPERVISOR_MODE && reg_rvalid) |-> (reg_rdata == '0));

endmodule

// File: tb/tb_ipi_swi_regs.sv
// Scoreboard bench: the driver updates a reference model and queues expected
// read data; a monitor compares outputs every falling edge.
module tb_ipi_swi_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NH         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [13:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        m_rv, s_rv;
    logic [31:0] m_rd, s_rd;
    logic [NH-1:0] m_irq, s_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_swi_regs #(.NUM_HARTS(NH), .SUPERVISOR_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rvalid(m_rv), .reg_rdata(m_rd), .swi_out(m_irq));

    ipi_swi_regs #(.NUM_HARTS(NH), .SUPERVISOR_MODE(1'b1)) dut_s (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rvalid(s_rv), .reg_rdata(s_rd), .swi_out(s_irq));

    int          checks = 0;
    int          fails  = 0;
    string       cur_req = "R1";
    logic [NH-1:0] m_exp = '0;
    logic [NH-1:0] s_exp = '0;
    logic [31:0] mq[$];
    logic [31:0] sq[$];
    bit          mon_on = 1'b0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Driver: apply one bus cycle, then advance the reference model.
    task automatic step(input bit s, input bit w, input logic [13:0] a, input logic [31:0] d);
        bit hit;
        int idx;
        @(negedge clk);
        reg_sel = s; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        idx = int'(a[13:2]);
        hit = (a[1:0] == 2'b00) && (idx < NH);
        s_exp = '0;
        if (s && !w) begin
            mq.push_back(hit ? {31'b0, m_exp[idx]} : 32'h0);
            sq.push_back(32'h0);
        end
        if (s && w && hit) begin
            if (d[0]) begin m_exp[idx] = 1'b1; s_exp[idx] = 1'b1; end
            else m_exp[idx] = 1'b0;
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d); step(1, 1, a, d); endtask
    task automatic rd(input logic [13:0] a); step(1, 0, a, 32'h0); endtask
    task automatic idle(); step(0, 0, 14'h0, 32'h0); endtask

    // Monitor: compare outputs and pop read responses.
    always @(negedge clk) begin
        if (mon_on) begin
            chk("machine irq", 32'(m_irq), 32'(m_exp));
            chk("supervisor irq", 32'(s_irq), 32'(s_exp));
            chk("machine rvalid", 32'(m_rv), 32'(mq.size() != 0));
            chk("supervisor rvalid", 32'(s_rv), 32'(sq.size() != 0));
            if (m_rv && mq.size() != 0) chk("machine rdata", m_rd, mq.pop_front());
            if (s_rv && sq.size() != 0) chk("supervisor rdata", s_rd, sq.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset state, all registers read zero
        cur_req = "R1";
        for (int h = 0; h < NH; h++) rd(14'(h * 4));
        idle();

        // R2 / R5: set hart 1, level held vs single pulse
        cur_req = "R2";
        wr(14'h4, 32'h1);
        cur_req = "R5";
        idle(); idle();

        // R4: read back pending state
        cur_req = "R4";
        rd(14'h4); rd(14'h0); idle();

        // R3: clear hart 1
        cur_req = "R3";
        wr(14'h4, 32'h0);
        rd(14'h4); idle();

        // R6: zero store in supervisor flavour gives no pulse
        cur_req = "R6";
        wr(14'h8, 32'h1);
        wr(14'h8, 32'h0);
        rd(14'h8); idle();

        // R7: upper write bits ignored
        cur_req = "R7";
        wr(14'hC, 32'h1);
        wr(14'hC, 32'hFFFF_FFFE);
        wr(14'h0, 32'h0000_0003);
        rd(14'hC); rd(14'h0); idle();

        // R8: misaligned accesses ignored, read zero (hart 0 is pending)
        cur_req = "R8";
        wr(14'h5, 32'h0);
        wr(14'h6, 32'h1);
        wr(14'h2, 32'h0);
        rd(14'h1); rd(14'h0); idle();

        // R9: out-of-range indices ignored, read zero
        cur_req = "R9";
        wr(14'h10, 32'h1);
        wr(14'h3FFC, 32'h1);
        rd(14'h10); rd(14'h3FFC); idle();

        // R10: writes touch only the addressed hart
        cur_req = "R10";
        for (int h = 0; h < NH; h++) wr(14'(h * 4), 32'h1);
        wr(14'h8, 32'h0);
        for (int h = 0; h < NH; h++) rd(14'(h * 4));
        idle(); idle();

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule